// File: doc/BRIEF.md
# Address Translator with Table-Walk Refill

This block turns a 32-bit virtual address into a 32-bit physical address with 4 KiB pages. The upper 20 bits (the page number) are translated and the low 12 bits (the offset inside the page) pass through unchanged. An eight-slot, fully associative translation cache answers a request in a single cycle when it holds the page. When it does not, a hardware walker reads one 32-bit entry from a flat page table in memory. It installs the mapping if the entry is marked present. If the entry is not present, it raises a page-fault pulse and latches the offending virtual address.

The requester sees a valid/ready request port and a one-cycle response strobe carrying the physical address, together with the request's write flag and write data. The walker fetches entries through a valid/ready memory read port. A software-visible table base register selects the table. Writing that register, or pulsing the flush input, empties the translation cache. After fault handling has repaired the table entry, software retries the access. The retry walks the table again and completes.

Top module: `addr_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `fault` and `mem_req_valid` are 0, `base_rdata` reads 0, and the translation cache is empty.
- R2: A request whose page is cached is answered with `rsp_valid` in the cycle after acceptance. The answer makes no memory request, and `rsp_paddr` is {cached physical page, vaddr[11:0]}.
- R3: On a cache miss the walker raises `mem_req_valid` with `mem_req_addr` = base + 4 × vaddr[31:12]. It holds valid and address steady until `mem_req_ready` is seen.
- R4: `req_ready` stays 0 from the cycle after a missing request is accepted until the cycle in which that walk's response or fault appears.
- R5: Page table entries carry the present flag in bit 0 and the physical page in bits 31:12. When the returned entry has bit 0 set, `rsp_valid` rises in the cycle after `mem_rsp_valid` with `rsp_paddr` = {entry[31:12], vaddr[11:0]}, and the mapping is installed so the next access to that page hits.
- R6: When the returned entry has bit 0 clear, `fault` pulses for exactly one cycle in place of `rsp_valid`. `fault_vaddr` captures the full virtual address and holds it until the next fault.
- R7: After the table entry for a faulting page has been made present, a retried access walks again and completes with the new translation.
- R8: A one-cycle `flush` pulse invalidates every cached translation and restarts the replacement order at slot 0.
- R9: Writing `base_we`/`base_wdata` loads the base with bits 11:0 forced to zero. `base_rdata` returns the stored base, and the write invalidates every cached translation as in R8.
- R10: Refills fill slots in round-robin order, so the ninth distinct page after a flush evicts the first page filled. Hits do not advance the order.
- R11: `rsp_write` and `rsp_wdata` return the write flag and write data of the request being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_wdata | input | 32 | Write data travelling with the access |
| rsp_valid | output | 1 | One-cycle strobe: translation done |
| rsp_paddr | output | 32 | Physical address |
| rsp_write | output | 1 | Write flag of the answered request |
| rsp_wdata | output | 32 | Write data of the answered request |
| fault | output | 1 | One-cycle page-fault pulse |
| fault_vaddr | output | 32 | Virtual address of the latest fault |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | 32 | New table base |
| base_rdata | output | 32 | Current table base |
| flush | input | 1 | Invalidate all cached translations |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Address of the table entry |
| mem_rsp_valid | input | 1 | Table entry returned |
| mem_rsp_data | input | 32 | Returned table entry |

## Verification
The embedded properties watch several rules on every cycle: the one-cycle answer after a cached hit, the steadiness of the table read request while memory stalls, the stall of the request port after a miss, the exclusivity and single-cycle width of the fault pulse, that at most one cache slot ever matches, and that nothing hits right after a flush. Other behaviour is only visible across a sequence of accesses, so the bench's scenarios are what show it: that an installed mapping really serves the next access, that the entry address is computed from the base, that a repaired entry lets a retry succeed, that base writes clear the cache and that the round-robin order evicts the right page.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;
  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_REQ  = 2'd1,
    WK_WAIT = 2'd2
  } walk_state_e;
endpackage

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q, vld_d, match;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q, ptr_d;

  // Compare and per-slot storage
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign match[i] = vld_q[i] && (tag_q[i] == lk_vpn);

    always_ff @(posedge clk) begin
      if (fill_en && !flush && (ptr_q == IDX_W'(i))) begin
        tag_q[i] <= fill_vpn;
        ppn_q[i] <= fill_ppn;
      end
    end
  end

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) lk_ppn = lk_ppn | ppn_q[i];
  end
  assign lk_hit = |match;

  // Next state: flush wins over a refill in the same cycle
  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (flush) begin
      vld_d = '0;
      ptr_d = '0;
    end else if (fill_en) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  p_single_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);
endmodule

// File: rtl/table_walker.sv
module table_walker
  import addr_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_vaddr,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_wdata,
  input  logic                    tlb_hit,
  input  logic [ADDR_W-OFF_W-1:0] tlb_ppn,
  output logic                    fill_en,
  output logic [ADDR_W-OFF_W-1:0] fill_vpn,
  output logic [ADDR_W-OFF_W-1:0] fill_ppn,
  input  logic [ADDR_W-1:0]       base,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [ADDR_W-1:0]       mem_rsp_data,
  output logic                    rsp_valid,
  output logic [ADDR_W-1:0]       rsp_paddr,
  output logic                    rsp_write,
  output logic [ADDR_W-1:0]       rsp_wdata,
  output logic                    fault,
  output logic [ADDR_W-1:0]       fault_vaddr
);
  localparam int VPN_W = ADDR_W - OFF_W;
  localparam int PAD_W = OFF_W - 2;

  walk_state_e       st_q, st_d;
  logic [ADDR_W-1:0] va_q, va_d, wd_q, wd_d;
  logic              wr_q, wr_d, cur_en;
  logic              rv_q, rv_d, flt_q, flt_d;
  logic [ADDR_W-1:0] pa_q, pa_d, wdo_q, wdo_d, fva_q, fva_d;
  logic              wro_q, wro_d, out_en, fva_en;
  logic              accept, pte_ok;

  assign accept = req_valid && (st_q == WK_IDLE);
  assign pte_ok = mem_rsp_data[0];

  always_comb begin
    st_d   = st_q;
    cur_en = 1'b0;
    va_d   = req_vaddr;
    wr_d   = req_write;
    wd_d   = req_wdata;
    rv_d   = 1'b0;
    flt_d  = 1'b0;
    out_en = 1'b0;
    pa_d   = {tlb_ppn, req_vaddr[OFF_W-1:0]};
    wro_d  = req_write;
    wdo_d  = req_wdata;
    fva_en = 1'b0;
    fva_d  = va_q;
    fill_en = 1'b0;
    unique case (st_q)
      WK_IDLE: if (accept) begin
        cur_en = 1'b1;
        if (tlb_hit) begin
          rv_d   = 1'b1;
          out_en = 1'b1;
        end else begin
          st_d = WK_REQ;
        end
      end
      WK_REQ: if (mem_req_ready) st_d = WK_WAIT;
      WK_WAIT: if (mem_rsp_valid) begin
        st_d = WK_IDLE;
        if (pte_ok) begin
          rv_d    = 1'b1;
          out_en  = 1'b1;
          fill_en = 1'b1;
          pa_d    = {mem_rsp_data[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
          wro_d   = wr_q;
          wdo_d   = wd_q;
        end else begin
          flt_d  = 1'b1;
          fva_en = 1'b1;
        end
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WK_IDLE;
      rv_q  <= 1'b0;
      flt_q <= 1'b0;
      fva_q <= '0;
    end else begin
      st_q  <= st_d;
      rv_q  <= rv_d;
      flt_q <= flt_d;
      if (fva_en) fva_q <= fva_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cur_en) begin
      va_q <= va_d;
      wr_q <= wr_d;
      wd_q <= wd_d;
    end
    if (out_en) begin
      pa_q  <= pa_d;
      wro_q <= wro_d;
      wdo_q <= wdo_d;
    end
  end

  assign req_ready     = (st_q == WK_IDLE);
  assign mem_req_valid = (st_q == WK_REQ);
  assign mem_req_addr  = base + {{PAD_W{1'b0}}, va_q[ADDR_W-1:OFF_W], 2'b00};
  assign fill_vpn      = va_q[ADDR_W-1:OFF_W];
  assign fill_ppn      = mem_rsp_data[ADDR_W-1:ADDR_W-VPN_W];
  assign rsp_valid     = rv_q;
  assign rsp_paddr     = pa_q;
  assign rsp_write     = wro_q;
  assign rsp_wdata     = wdo_q;
  assign fault         = flt_q;
  assign fault_vaddr   = fva_q;

  p_hit_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tlb_hit) |=> (rsp_valid && !mem_req_valid));
  p_req_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  p_miss_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !tlb_hit) |=> !req_ready);
  p_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && rsp_valid));
  p_fault_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_write,
  output logic [ADDR_W-1:0] rsp_wdata,
  output logic              fault,
  output logic [ADDR_W-1:0] fault_vaddr,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic [ADDR_W-1:0] base_rdata,
  input  logic              flush,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);
  localparam int VPN_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] base_q, base_d;
  logic              hit, fill_en, cache_clr;
  logic [VPN_W-1:0]  hit_ppn, fill_vpn, fill_ppn;

  assign base_d    = {base_wdata[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign cache_clr = flush || base_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_d;
  end
  assign base_rdata = base_q;

  xlate_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(VPN_W)) u_cache (
    .clk(clk), .rst_n(rst_n), .flush(cache_clr),
    .lk_vpn(req_vaddr[ADDR_W-1:OFF_W]), .lk_hit(hit), .lk_ppn(hit_ppn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
  );

  table_walker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_wdata(req_wdata),
    .tlb_hit(hit), .tlb_ppn(hit_ppn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .base(base_q),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_write(rsp_write),
    .rsp_wdata(rsp_wdata), .fault(fault), .fault_vaddr(fault_vaddr)
  );

  p_base_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[OFF_W-1:0] == '0);
endmodule

// File: tb/addr_xlate_test.sv
`timescale 1ns/1ps
module addr_xlate_test;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_vaddr, req_wdata;
  logic        rsp_valid, rsp_write, fault;
  logic [31:0] rsp_paddr, rsp_wdata, fault_vaddr;
  logic        base_we, flush;
  logic [31:0] base_wdata, base_rdata;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;

  addr_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_write(rsp_write),
    .rsp_wdata(rsp_wdata), .fault(fault), .fault_vaddr(fault_vaddr),
    .base_we(base_we), .base_wdata(base_wdata), .base_rdata(base_rdata),
    .flush(flush), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, walks = 0, ph = 0;
  logic [31:0] pt [64];
  logic [31:0] tb_base = 32'h0010_0000;
  logic [31:0] last_addr;
  logic        got_wr;
  logic [31:0] got_wd;

  typedef struct packed {
    logic [31:0] va; logic wr; logic [31:0] wd;
    logic flt; logic [31:0] pa; logic [1:0] nw;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{32'h0000_1ABC, 1'b0, 32'h0,         1'b0, 32'hA000_1ABC, 2'd1},
    '{32'h0000_1FFC, 1'b1, 32'hCAFE_0001, 1'b0, 32'hA000_1FFC, 2'd0},
    '{32'h0000_2000, 1'b1, 32'h1234_5678, 1'b0, 32'hA000_2000, 2'd1},
    '{32'h0000_5123, 1'b0, 32'h0,         1'b1, 32'h0,         2'd1},
    '{32'h0000_2777, 1'b0, 32'h0,         1'b0, 32'hA000_2777, 2'd0},
    '{32'h0000_5000, 1'b1, 32'h0BAD_F00D, 1'b1, 32'h0,         2'd1}
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Memory model: grants one negedge after the request, answers one later
  always @(negedge clk) begin
    case (ph)
      0: if (mem_req_valid) begin
        mem_req_ready = 1'b1; last_addr = mem_req_addr; walks++; ph = 1;
      end
      1: begin
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b1;
        mem_rsp_data = pt[6'((last_addr - tb_base) >> 2)]; ph = 2;
      end
      default: begin mem_rsp_valid = 1'b0; ph = 0; end
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
      summary();
    end
  end

  task automatic xlate(input logic [31:0] va, input logic wr, input logic [31:0] wd,
                       output logic [31:0] pa, output logic flt, output int lat, output int nw);
    int w0;
    w0 = walks;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; lat = 1;
    while (!rsp_valid && !fault && lat < 200) begin
      chk(!req_ready, "R4 stall during walk", {31'b0, req_ready}, 32'h0);
      @(negedge clk); lat++;
    end
    pa = rsp_paddr; flt = fault; got_wr = rsp_write; got_wd = rsp_wdata;
    nw = walks - w0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic expect_ok(input logic [31:0] va, input logic [31:0] pa_exp,
                           input int nw_exp, input string rq);
    logic [31:0] pa; logic f; int lat, nw;
    xlate(va, 1'b0, 32'h0, pa, f, lat, nw);
    chk(!f, rq, {31'b0, f}, 32'h0);
    chk(pa == pa_exp, rq, pa, pa_exp);
    chk(nw == nw_exp, rq, nw, nw_exp);
  endtask

  initial begin
    logic [31:0] pa; logic f; int lat, nw;
    for (int i = 0; i < 64; i++)
      pt[i] = (i == 5) ? 32'h0 : {20'hA0000 + 20'(i), 12'h001};
    rst_n = 1'b0; req_valid = 0; req_vaddr = 0; req_write = 0; req_wdata = 0;
    base_we = 0; base_wdata = 0; flush = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready === 1'b1, "R1 req_ready", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid === 1'b0 && fault === 1'b0, "R1 rsp/fault idle", {30'b0, rsp_valid, fault}, 32'h0);
    chk(mem_req_valid === 1'b0, "R1 mem_req_valid", {31'b0, mem_req_valid}, 32'h0);
    chk(base_rdata === 32'h0, "R1 base", base_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); base_we = 1'b1; base_wdata = tb_base;
    @(negedge clk); base_we = 1'b0;

    // Vector table: R2 R3 R5 R6 R11
    for (int v = 0; v < 6; v++) begin
      xlate(VECS[v].va, VECS[v].wr, VECS[v].wd, pa, f, lat, nw);
      chk(f == VECS[v].flt, "R5/R6 fault flag", {31'b0, f}, {31'b0, VECS[v].flt});
      chk(nw == int'(VECS[v].nw), "R2/R3 walk count", nw, VECS[v].nw);
      chk(lat == ((VECS[v].nw == 0) ? 1 : 3), "R2/R5 latency", lat, (VECS[v].nw == 0) ? 1 : 3);
      if (!VECS[v].flt) begin
        chk(pa == VECS[v].pa, "R2/R5 paddr", pa, VECS[v].pa);
        chk(got_wr == VECS[v].wr && got_wd == VECS[v].wd, "R11 write passthrough",
            got_wd, VECS[v].wd);
      end else begin
        chk(fault_vaddr == VECS[v].va, "R6 fault_vaddr", fault_vaddr, VECS[v].va);
        @(negedge clk);
        chk(!fault && fault_vaddr == VECS[v].va, "R6 one-cycle pulse, held addr",
            fault_vaddr, VECS[v].va);
      end
      if (v == 0) chk(last_addr == 32'h0010_0004, "R3 entry address", last_addr, 32'h0010_0004);
    end

    // R7: repair entry 5 and retry
    pt[5] = 32'hB000_5001;
    expect_ok(32'h0000_5010, 32'hB000_5010, 1, "R7 retry walk");
    expect_ok(32'h0000_5FF0, 32'hB000_5FF0, 0, "R7 retry installs");

    // R8: flush forces a fresh walk
    pulse_flush();
    expect_ok(32'h0000_1000, 32'hA000_1000, 1, "R8 flush invalidates");

    // R9: base write aligns, reads back, invalidates
    tb_base = 32'h0020_0000;
    @(negedge clk); base_we = 1'b1; base_wdata = 32'h0020_0ABC;
    @(negedge clk); base_we = 1'b0;
    chk(base_rdata == 32'h0020_0000, "R9 base aligned", base_rdata, 32'h0020_0000);
    expect_ok(32'h0000_2004, 32'hA000_2004, 1, "R9 base write invalidates");
    chk(last_addr == 32'h0020_0008, "R9/R3 new base address", last_addr, 32'h0020_0008);

    // R10: round-robin replacement after flush
    pulse_flush();
    for (int p = 10; p < 18; p++)
      expect_ok({20'(p), 12'h0}, {20'hA0000 + 20'(p), 12'h0}, 1, "R10 fill eight");
    expect_ok(32'h0000_A000, 32'hA000_A000, 0, "R10 hit keeps order");
    expect_ok(32'h0001_2000, 32'hA001_2000, 1, "R10 ninth page");
    expect_ok(32'h0000_A000, 32'hA000_A000, 1, "R10 oldest evicted");
    expect_ok(32'h0000_C000, 32'hA000_C000, 0, "R10 third slot kept");
    expect_ok(32'h0000_B000, 32'hA000_B000, 1, "R10 second slot evicted");

    summary();
  end
endmodule